// File: doc/BRIEF.md
# Multiplierless Eight-Point FFT Engine

This block computes a complete eight-point complex discrete Fourier transform in one pass of combinational logic and registers the result. Eight complex samples arrive in parallel on two packed buses, one for the real halves and one for the imaginary halves. A sample qualifier marks a valid set. One clock edge later, eight frequency bins in natural order leave the block with a matching qualifier. A new set can be accepted on every clock.

Internally, the samples are reordered into bit-reversed position and pass through three radix-2 decimation-in-time butterfly ranks. The only rotations needed at eight points are by one, by -j, and by the two diagonal factors. The diagonal factors are built from a fixed network of arithmetic shifts and adders that approximates 0.707, so the block contains no general multiplier. Each rank widens the working word. The final sums are divided by eight with an arithmetic shift and then clipped back to the sample width.

An inverse transform is obtained without touching the block: exchange the real and imaginary buses at the input, then exchange them again at the output. The larger transform that surrounds this engine supplies its own inter-stage factors and serialisation.

Top module: `fft8_shiftadd`

## Requirements
- R1: When `in_valid` is high, the next registered output holds, for each bin k in 0..7, floor(X[k]/8) saturated, where X[k] = sum over n of x[n]·e^(-j2πkn/8). The result is within 8 LSB per component. Sample and bin n occupy bits [16n+15:16n] of their real and imaginary buses.
- R2: `out_valid` equals the value `in_valid` had at the previous rising clock edge.
- R3: While `in_valid` is low, `out_re` and `out_im` keep their values, whatever the sample buses carry.
- R4: While `rst_n` is low at a rising edge, `out_valid`, `out_re` and `out_im` become zero, even if `in_valid` is high.
- R5: A scaled bin component above 32767 is output as 32767, and one below -32768 is output as -32768. There is no wrap-around.
- R6: If all eight input samples are equal, bin 0 equals that sample exactly and bins 1 to 7 are exactly zero.
- R7: Exchanging the real and imaginary buses at both input and output yields floor of (sum over n of x[n]·e^(+j2πkn/8))/8, within 8 LSB.
- R8: If samples 1 to 7 are zero, every bin equals sample 0 shifted arithmetically right by three, exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The sample buses hold a set to transform |
| in_re | input | 128 | Real parts of samples 0..7, 16-bit two's complement each |
| in_im | input | 128 | Imaginary parts of samples 0..7 |
| out_valid | output | 1 | The bin buses hold a new result |
| out_re | output | 128 | Real parts of bins 0..7 |
| out_im | output | 128 | Imaginary parts of bins 0..7 |

## Verification
Since there is only one register between input and output, a fault anywhere in the datapath shows up in the very next cycle's bins. No history hides it. A mis-wired reordering or a swapped butterfly operand leaves symmetric inputs, such as a constant or an impulse at sample 0, untouched. It does corrupt bins for asymmetric random sets. A fault in the diagonal shift-and-add network changes only the odd bins. A lost guard bit or a missing clip shows up only near full scale, as a sign flip in place of 32767 or -32768.

// File: rtl/fft8_pkg.sv
package fft8_pkg;

   localparam int LANES  = 8;
   localparam int STAGES = 3;

   // rotation applied to the lower butterfly operand
   typedef enum logic [1:0] {
      TW_ONE = 2'd0,   // multiply by 1
      TW_W1  = 2'd1,   // multiply by e^(-j*pi/4)
      TW_MJ  = 2'd2,   // multiply by -j
      TW_W3  = 2'd3    // multiply by e^(-j*3pi/4)
   } tw_e;

   function automatic int unsigned rev3(input int unsigned idx);
      logic [2:0] v;
      v = idx[2:0];
      return int'({v[0], v[1], v[2]});
   endfunction

   function automatic tw_e tw_of(input int unsigned k);
      case (k)
         0:       return TW_ONE;
         1:       return TW_W1;
         2:       return TW_MJ;
         default: return TW_W3;
      endcase
   endfunction

endpackage

// File: rtl/fft8_c45.sv
// Constant scaler: dout = sum of din >>> k for every k with MASK[k] set.
module fft8_c45 #(
   parameter int             WD   = 20,
   parameter int             FRAC = 8,
   parameter logic [FRAC:0]  MASK = 9'h15A
) (
   input  logic signed [WD-1:0] din,
   output logic signed [WD-1:0] dout
);

   if (FRAC < 1 || FRAC >= WD) begin : g_bad_frac
      $error("fft8_c45: FRAC out of range");
   end
   if (MASK[0]) begin : g_bad_mask
      $error("fft8_c45: coefficient must be below one");
   end

   logic signed [WD-1:0] acc [FRAC+1];

   assign acc[0] = '0;

   for (genvar k = 1; k <= FRAC; k++) begin : g_term
      if (MASK[k]) begin : g_add
         assign acc[k] = acc[k-1] + (din >>> k);
      end else begin : g_skip
         assign acc[k] = acc[k-1];
      end
   end

   assign dout = acc[FRAC];

endmodule

// File: rtl/fft8_rot.sv
// Fixed rotation by one of the eight-point twiddles, no multiplier.
module fft8_rot #(
   parameter int                WD   = 20,
   parameter fft8_pkg::tw_e     KIND = fft8_pkg::TW_ONE,
   parameter int                FRAC = 8,
   parameter logic [FRAC:0]     MASK = 9'h15A
) (
   input  logic signed [WD-1:0] re_i,
   input  logic signed [WD-1:0] im_i,
   output logic signed [WD-1:0] re_o,
   output logic signed [WD-1:0] im_o
);

   if (KIND == fft8_pkg::TW_ONE) begin : g_one
      assign re_o = re_i;
      assign im_o = im_i;
   end else if (KIND == fft8_pkg::TW_MJ) begin : g_mj
      assign re_o = im_i;
      assign im_o = -re_i;
   end else begin : g_diag
      logic signed [WD-1:0] sum_v, dif_v, sum_s, dif_s;
      assign sum_v = re_i + im_i;
      assign dif_v = im_i - re_i;

      fft8_c45 #(.WD(WD), .FRAC(FRAC), .MASK(MASK)) u_sum (
         .din (sum_v),
         .dout(sum_s)
      );
      fft8_c45 #(.WD(WD), .FRAC(FRAC), .MASK(MASK)) u_dif (
         .din (dif_v),
         .dout(dif_s)
      );

      if (KIND == fft8_pkg::TW_W1) begin : g_w1
         assign re_o = sum_s;
         assign im_o = dif_s;
      end else begin : g_w3
         assign re_o = dif_s;
         assign im_o = -sum_s;
      end
   end

endmodule

// File: rtl/fft8_bfly.sv
// Radix-2 butterfly: p = a + W*b, m = a - W*b.
module fft8_bfly #(
   parameter int                WD   = 20,
   parameter fft8_pkg::tw_e     KIND = fft8_pkg::TW_ONE,
   parameter int                FRAC = 8,
   parameter logic [FRAC:0]     MASK = 9'h15A
) (
   input  logic signed [WD-1:0] a_re,
   input  logic signed [WD-1:0] a_im,
   input  logic signed [WD-1:0] b_re,
   input  logic signed [WD-1:0] b_im,
   output logic signed [WD-1:0] p_re,
   output logic signed [WD-1:0] p_im,
   output logic signed [WD-1:0] m_re,
   output logic signed [WD-1:0] m_im
);

   logic signed [WD-1:0] t_re, t_im;

   fft8_rot #(.WD(WD), .KIND(KIND), .FRAC(FRAC), .MASK(MASK)) u_rot (
      .re_i(b_re),
      .im_i(b_im),
      .re_o(t_re),
      .im_o(t_im)
   );

   assign p_re = a_re + t_re;
   assign p_im = a_im + t_im;
   assign m_re = a_re - t_re;
   assign m_im = a_im - t_im;

endmodule

// File: rtl/fft8_shiftadd.sv
module fft8_shiftadd #(
   parameter int            W    = 16,
   parameter int            FRAC = 8,
   parameter logic [FRAC:0] MASK = 9'h15A
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              in_valid,
   input  logic [fft8_pkg::LANES*W-1:0]      in_re,
   input  logic [fft8_pkg::LANES*W-1:0]      in_im,
   output logic                              out_valid,
   output logic [fft8_pkg::LANES*W-1:0]      out_re,
   output logic [fft8_pkg::LANES*W-1:0]      out_im
);

   localparam int N  = fft8_pkg::LANES;
   localparam int NS = fft8_pkg::STAGES;
   localparam int WX = W + NS + 1;   // one bit per rank plus rotation guard
   localparam int SH = NS;           // divide by N
   localparam logic signed [WX-1:0] MAXV = WX'((longint'(1) <<< (W-1)) - 1);
   localparam logic signed [WX-1:0] MINV = ~MAXV;

   if (W < 4 || W > 30) begin : g_bad_w
      $error("fft8_shiftadd: W out of range");
   end
   if (FRAC >= WX) begin : g_bad_frac
      $error("fft8_shiftadd: FRAC too large for working width");
   end
   if (N != (1 << NS)) begin : g_bad_n
      $error("fft8_shiftadd: lane count and rank count disagree");
   end

   logic signed [WX-1:0] st_re [NS+1][N];
   logic signed [WX-1:0] st_im [NS+1][N];
   logic [N*W-1:0]       sat_re, sat_im;

   // bit-reversed load, sign-extended to working width
   for (genvar i = 0; i < N; i++) begin : g_load
      localparam int SRC = int'(fft8_pkg::rev3(i));
      logic signed [W-1:0] xr, xi;
      assign xr = in_re[W*SRC +: W];
      assign xi = in_im[W*SRC +: W];
      assign st_re[0][i] = WX'(xr);
      assign st_im[0][i] = WX'(xi);
   end

   // three decimation-in-time ranks
   for (genvar s = 0; s < NS; s++) begin : g_rank
      localparam int H = 1 << s;
      for (genvar p = 0; p < N; p++) begin : g_pos
         if ((p % (2*H)) < H) begin : g_bf
            localparam int K = (p % H) * (N / (2*H));
            fft8_bfly #(
               .WD  (WX),
               .KIND(fft8_pkg::tw_of(K)),
               .FRAC(FRAC),
               .MASK(MASK)
            ) u_bf (
               .a_re(st_re[s][p]),
               .a_im(st_im[s][p]),
               .b_re(st_re[s][p+H]),
               .b_im(st_im[s][p+H]),
               .p_re(st_re[s+1][p]),
               .p_im(st_im[s+1][p]),
               .m_re(st_re[s+1][p+H]),
               .m_im(st_im[s+1][p+H])
            );
         end
      end
   end

   // scale by 1/N and clip to the sample width
   for (genvar i = 0; i < N; i++) begin : g_out
      logic signed [WX-1:0] shr, shi;
      assign shr = st_re[NS][i] >>> SH;
      assign shi = st_im[NS][i] >>> SH;
      assign sat_re[W*i +: W] = (shr > MAXV) ? MAXV[W-1:0] :
                                (shr < MINV) ? MINV[W-1:0] : shr[W-1:0];
      assign sat_im[W*i +: W] = (shi > MAXV) ? MAXV[W-1:0] :
                                (shi < MINV) ? MINV[W-1:0] : shi[W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_re    <= '0;
         out_im    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_re <= sat_re;
            out_im <= sat_im;
         end
      end
   end

endmodule

// File: rtl/fft8_shiftadd_chk.sv
module fft8_shiftadd_chk #(
   parameter int W = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic [8*W-1:0] in_re,
   input logic [8*W-1:0] in_im,
   input logic          out_valid,
   input logic [8*W-1:0] out_re,
   input logic [8*W-1:0] out_im
);

   localparam int N = 8;

   logic               dc_in, imp_in;
   logic [N*W-1:0]     dc_re_exp, dc_im_exp, imp_re_exp, imp_im_exp;
   logic signed [W-1:0] x0r, x0i;

   assign x0r = in_re[W-1:0];
   assign x0i = in_im[W-1:0];

   always_comb begin
      dc_in  = 1'b1;
      imp_in = 1'b1;
      for (int i = 1; i < N; i++) begin
         if (in_re[W*i +: W] != in_re[W-1:0] || in_im[W*i +: W] != in_im[W-1:0])
            dc_in = 1'b0;
         if (in_re[W*i +: W] != '0 || in_im[W*i +: W] != '0)
            imp_in = 1'b0;
      end
      dc_re_exp = '0;
      dc_im_exp = '0;
      dc_re_exp[W-1:0] = in_re[W-1:0];
      dc_im_exp[W-1:0] = in_im[W-1:0];
      for (int i = 0; i < N; i++) begin
         imp_re_exp[W*i +: W] = W'(x0r >>> 3);
         imp_im_exp[W*i +: W] = W'(x0i >>> 3);
      end
   end

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (out_valid == $past(in_valid)));                 // R2

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(in_valid)) |-> ($stable(out_re) && $stable(out_im))); // R3

   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (!out_valid && out_re == '0 && out_im == '0));  // R4

   AST_DC_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_valid && dc_in)) |->
      (out_re == $past(dc_re_exp) && out_im == $past(dc_im_exp)));     // R6

   AST_IMPULSE_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_valid && imp_in)) |->
      (out_re == $past(imp_re_exp) && out_im == $past(imp_im_exp)));   // R8

endmodule

bind fft8_shiftadd fft8_shiftadd_chk #(.W(W)) u_chk (.*);

// File: tb/fft8_shiftadd_test.sv
module fft8_shiftadd_test;

   localparam int  W   = 16;
   localparam int  N   = 8;
   localparam int  TOL = 8;
   localparam real PI  = 3.14159265358979323846;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           in_valid;
   logic [N*W-1:0] in_re, in_im;
   logic           out_valid;
   logic [N*W-1:0] out_re, out_im;

   always #5 clk = ~clk;

   fft8_shiftadd uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_re    (in_re),
      .in_im    (in_im),
      .out_valid(out_valid),
      .out_re   (out_re),
      .out_im   (out_im)
   );

   int xr[N], xi[N], er[N], ei[N];
   int checks = 0;
   int fails  = 0;

   task automatic chk(input string rq, input string what, input int act, input int exp, input int tol);
      int d;
      checks++;
      d = act - exp;
      if (d < 0) d = -d;
      if (d > tol) begin
         fails++;
         $display("FAIL %s %s act=%0d exp=%0d", rq, what, act, exp);
      end
   endtask

   function automatic int satw(input real v);
      real f;
      f = $floor(v);
      if (f > 32767.0)  return 32767;
      if (f < -32768.0) return -32768;
      return int'(f);
   endfunction

   function automatic int lane(input logic [N*W-1:0] bus, input int k);
      logic signed [W-1:0] v;
      v = bus[W*k +: W];
      return int'(v);
   endfunction

   task automatic ref_dft(input bit inv);
      for (int k = 0; k < N; k++) begin
         real sr, si, th, c, s;
         sr = 0.0; si = 0.0;
         for (int n = 0; n < N; n++) begin
            th = 2.0 * PI * real'(k * n) / real'(N);
            c = $cos(th); s = $sin(th);
            if (!inv) begin
               sr += real'(xr[n]) * c + real'(xi[n]) * s;
               si += real'(xi[n]) * c - real'(xr[n]) * s;
            end else begin
               sr += real'(xr[n]) * c - real'(xi[n]) * s;
               si += real'(xi[n]) * c + real'(xr[n]) * s;
            end
         end
         er[k] = satw(sr / 8.0);
         ei[k] = satw(si / 8.0);
      end
   endtask

   // drive the current sample set; swap exchanges the buses
   task automatic drive(input bit swap);
      in_valid = 1'b1;
      for (int n = 0; n < N; n++) begin
         in_re[W*n +: W] = W'(swap ? xi[n] : xr[n]);
         in_im[W*n +: W] = W'(swap ? xr[n] : xi[n]);
      end
   endtask

   // apply one set, wait for the registered result, compare against reference
   task automatic run_set(input string rq, input bit inv);
      ref_dft(inv);
      drive(inv);
      @(negedge clk);
      chk("R2", "out_valid", int'(out_valid), 1, 0);
      for (int k = 0; k < N; k++) begin
         chk(rq, $sformatf("bin%0d re", k), inv ? lane(out_im, k) : lane(out_re, k), er[k], TOL);
         chk(rq, $sformatf("bin%0d im", k), inv ? lane(out_re, k) : lane(out_im, k), ei[k], TOL);
      end
   endtask

   function automatic int rnd_sample(input int cls);
      case (cls)
         0:       return int'($signed(16'($urandom)));
         1:       return int'($urandom % 2047) - 1023;
         default: return int'($urandom % 31) - 15;
      endcase
   endfunction

   initial begin
      #2000000;
      fails++;
      $display("FAIL R2 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [N*W-1:0] held_re, held_im;
      void'($urandom(32'd20240517));
      rst_n = 1'b0;
      in_valid = 1'b0;
      in_re = '0;
      in_im = '0;
      @(negedge clk);
      in_valid = 1'b1;
      in_re = {N{16'h7ABC}};
      in_im = {N{16'h8123}};
      repeat (3) @(negedge clk);
      // R4: reset wins over a valid set
      chk("R4", "out_valid", int'(out_valid), 0, 0);
      chk("R4", "out_re zero", int'(out_re != '0), 0, 0);
      chk("R4", "out_im zero", int'(out_im != '0), 0, 0);
      in_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2", "idle out_valid", int'(out_valid), 0, 0);

      // R6: constant input
      for (int n = 0; n < N; n++) begin xr[n] = 1234; xi[n] = -77; end
      drive(1'b0);
      @(negedge clk);
      chk("R6", "bin0 re", lane(out_re, 0), 1234, 0);
      chk("R6", "bin0 im", lane(out_im, 0), -77, 0);
      for (int k = 1; k < N; k++) begin
         chk("R6", $sformatf("bin%0d re", k), lane(out_re, k), 0, 0);
         chk("R6", $sformatf("bin%0d im", k), lane(out_im, k), 0, 0);
      end

      // R8: impulse at sample 0
      for (int n = 0; n < N; n++) begin xr[n] = 0; xi[n] = 0; end
      xr[0] = -32768; xi[0] = 20001;
      drive(1'b0);
      @(negedge clk);
      for (int k = 0; k < N; k++) begin
         chk("R8", $sformatf("bin%0d re", k), lane(out_re, k), -32768 >>> 3, 0);
         chk("R8", $sformatf("bin%0d im", k), lane(out_im, k), 20001 >>> 3, 0);
      end

      // R5: full-scale corners that push bin 1 past the range
      begin
         int pr[N] = '{1, 1, -1, -1, -1, -1, 1, 1};
         int pi[N] = '{1, 1, 1, 1, -1, -1, -1, -1};
         for (int n = 0; n < N; n++) begin xr[n] = 32767 * pr[n]; xi[n] = 32767 * pi[n]; end
         run_set("R1", 1'b0);
         chk("R5", "bin1 re clip high", lane(out_re, 1), 32767, 0);
         for (int n = 0; n < N; n++) begin xr[n] = -xr[n]; xi[n] = -xi[n]; end
         run_set("R1", 1'b0);
         chk("R5", "bin1 re clip low", lane(out_re, 1), -32768, 0);
      end

      // R1: random sets back to back, three amplitude classes
      for (int v = 0; v < 300; v++) begin
         int cls;
         cls = int'($urandom % 3);
         for (int n = 0; n < N; n++) begin
            xr[n] = rnd_sample(cls);
            xi[n] = rnd_sample(cls);
         end
         run_set("R1", 1'b0);
      end

      // R7: inverse through bus exchange
      for (int v = 0; v < 60; v++) begin
         for (int n = 0; n < N; n++) begin
            xr[n] = rnd_sample(v % 2);
            xi[n] = rnd_sample(v % 2);
         end
         run_set("R7", 1'b1);
      end

      // R3: idle cycles with changing buses leave the bins alone
      held_re = out_re;
      held_im = out_im;
      for (int v = 0; v < 5; v++) begin
         in_valid = 1'b0;
         in_re = {$urandom, $urandom, $urandom, $urandom};
         in_im = {$urandom, $urandom, $urandom, $urandom};
         @(negedge clk);
         chk("R2", "out_valid low", int'(out_valid), 0, 0);
         chk("R3", "out_re held", int'(out_re != held_re), 0, 0);
         chk("R3", "out_im held", int'(out_im != held_im), 0, 0);
      end

      // R2: single-cycle pulse
      for (int n = 0; n < N; n++) begin xr[n] = n * 100; xi[n] = -n * 50; end
      run_set("R1", 1'b0);
      in_valid = 1'b0;
      @(negedge clk);
      chk("R2", "pulse end", int'(out_valid), 0, 0);

      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end

endmodule